// File: doc/BRIEF.md
# Serial EEPROM Slave on SPI

This block is a synthesizable slave that answers a host the way a small SPI serial EEPROM would. It oversamples the serial pins with the system clock, shifts in 8-bit commands most significant bit first, and keeps a 512-byte register array behind them. The host drives SI, and the slave drives SO only while it returns data. A write-enable latch guards every change to storage. A status byte reports the latch and a busy flag.

A write sends data into a 16-byte page buffer. When chip select is released on a byte boundary, the buffer is copied into the array and an internal write cycle starts. That cycle lasts a parameterised number of clock cycles. While it runs, the slave answers only the status-read command. Reads stream bytes from any address and run on across the whole array.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Command 0x06 sets the write-enable latch and command 0x04 clears it. Status bit 1 always shows the latch.
- R2: Command 0x05 returns the status byte: bit 0 is busy, bit 1 is the latch, bits 2, 3 and 7 are the stored bits, and bits 4 to 6 read 0. The byte is sent again, refreshed, for as long as chip select stays low.
- R3: Command 0x01 followed by one byte is accepted only with the latch set. Of that byte it stores bits 2, 3 and 7 only, and only if chip select rises on a byte boundary. That event starts a write cycle.
- R4: Command 0000_A010 (A is address bit 8) is followed by an address byte and data bytes. It is accepted only with the latch set. The data reach the array only if chip select rises on a byte boundary. A trailing partial byte discards the whole transfer.
- R5: During a write, after each data byte only the low 4 address bits advance. Past the end of the page, the address wraps to the start of the same page and overwrites bytes already loaded.
- R6: Command 0000_A011 plus an address byte streams bytes from that address. The address advances across the whole array and wraps from 0x1FF to 0x000.
- R7: A committed write or status update holds status bit 0 at 1 for WRITE_CLKS clock cycles, then clears it.
- R8: While a write cycle runs, every command except 0x05 is ignored: the latch, the stored status bits and the array stay unchanged, and SO stays undriven.
- R9: The write-enable latch clears by itself when the write cycle ends.
- R10: SI is sampled on rising SCK and SO changes on falling SCK, in both mode 0 and mode 3. The output enable is low during command, address and data-in bytes.
- R11: After reset the status byte is 0x00 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data in (SI) |
| spi_miso | output | 1 | Serial data out value (SO) |
| spi_miso_en | output | 1 | SO output enable; high only while data is returned |

## Verification
The bench builds the block at its default 512-byte array with 16-byte pages. At that size the address bit carried in the command byte is exercised, as are the wrap from the top of the array to address zero and the page wrap at the upper end. WRITE_CLKS is set to 1200 clocks, and each serial bit lasts 16 clocks. At these settings a single long status read covers both the busy and the ready phase. There is also time for several ignored commands to be issued inside one write cycle. Four full pages are written and streamed back in one read, in both SPI modes.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SRDATA,
    ST_SRIN,
    ST_SKIP
  } ee_state_t;

  localparam logic [7:0] CMD_LATCH_ON  = 8'h06;
  localparam logic [7:0] CMD_LATCH_OFF = 8'h04;
  localparam logic [7:0] CMD_STAT_RD   = 8'h05;
  localparam logic [7:0] CMD_STAT_WR   = 8'h01;
  localparam logic [2:0] CMD_LOW_RD    = 3'b011;
  localparam logic [2:0] CMD_LOW_WR    = 3'b010;

  // keep only the writable status bits {7,3,2}
  function automatic logic [2:0] sr_pick(input logic [7:0] w);
    return {w[7], w[3], w[2]};
  endfunction

  // rebuild the visible status byte
  function automatic logic [7:0] sr_build(input logic [2:0] nv, input logic wel, input logic busy);
    return {nv[2], 3'b000, nv[1], nv[0], wel, busy};
  endfunction

endpackage

// File: rtl/sspi_sync.sv
module sspi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csn,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic cs_start,
  output logic cs_end,
  output logic si_s
);
  logic [2:0] pipe [STAGES];
  logic       sck_prev, csn_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= 3'b010;
      sck_prev <= 1'b0;
      csn_prev <= 1'b1;
    end else begin
      pipe[0] <= {si, csn, sck};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sck_prev <= pipe[STAGES-1][0];
      csn_prev <= pipe[STAGES-1][1];
    end
  end

  assign cs_act   = ~pipe[STAGES-1][1];
  assign si_s     = pipe[STAGES-1][2];
  assign sck_rise = cs_act &  pipe[STAGES-1][0] & ~sck_prev;
  assign sck_fall = cs_act & ~pipe[STAGES-1][0] &  sck_prev;
  assign cs_start = ~pipe[STAGES-1][1] &  csn_prev;
  assign cs_end   =  pipe[STAGES-1][1] & ~csn_prev;
endmodule

// File: rtl/sspi_rx.sv
module sspi_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       sck_rise,
  input  logic       si,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       at_bound
);
  logic [2:0] cnt;
  logic [6:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (!cs_act) begin
      cnt <= '0;
    end else if (sck_rise) begin
      sh  <= {sh[5:0], si};
      cnt <= cnt + 3'd1;
    end
  end

  assign byte_done = sck_rise & (cnt == 3'd7);
  assign rx_byte   = {sh, si};
  assign at_bound  = (cnt == 3'd0);

  assert_bound_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && cs_act) |=> at_bound);
endmodule

// File: rtl/ee_wtimer.sv
module ee_wtimer #(
  parameter int CLKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CLKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end
  end

  assign done = busy & (cnt == CW'(CLKS - 1));

  assert_busy_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_busy_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int WRITE_CLKS  = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_csn,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_en
);
  import eeprom_pkg::*;

  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  // advance inside the page only
  function automatic logic [AW-1:0] page_step(input logic [AW-1:0] a);
    return {a[AW-1:PW], a[PW-1:0] + 1'b1};
  endfunction

  function automatic logic [AW-1:0] full_addr(input logic hi, input logic [7:0] lo);
    logic [8:0] t;
    t = {hi, lo};
    return t[AW-1:0];
  endfunction

  logic sck_rise, sck_fall, cs_act, cs_start, cs_end, si_s;
  logic byte_done, at_bound;
  logic [7:0] rx_byte;
  logic busy, cyc_end;

  sspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .csn(spi_csn), .si(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
    .cs_start(cs_start), .cs_end(cs_end), .si_s(si_s)
  );

  sspi_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise), .si(si_s),
    .byte_done(byte_done), .rx_byte(rx_byte), .at_bound(at_bound)
  );

  ee_state_t             state;
  logic                  wel, op_hi, is_read, got_sr, out_first, so_oe_q;
  logic [2:0]            sr_nv, sr_new, obit;
  logic [AW-1:0]         addr;
  logic [7:0]            out_byte;
  logic [7:0]            mem  [MEM_BYTES];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pval;
  logic [7:0]            status_word;

  assign status_word = sr_build(sr_nv, wel, busy);

  // named events for the checks
  logic commit_wr, commit_sr, wr_byte_evt, out_state;
  assign commit_wr   = cs_end & (state == ST_WDATA) & at_bound & (|pval);
  assign commit_sr   = cs_end & (state == ST_SRIN) & at_bound & got_sr;
  assign wr_byte_evt = byte_done & (state == ST_WDATA);
  assign out_state   = (state == ST_RDATA) | (state == ST_SRDATA);

  ee_wtimer #(.CLKS(WRITE_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(commit_wr | commit_sr),
    .busy(busy), .done(cyc_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CMD;  wel <= 1'b0;  op_hi <= 1'b0;  is_read <= 1'b0;
      got_sr <= 1'b0;   sr_nv <= '0;  sr_new <= '0;   addr <= '0;
      pval <= '0;       out_byte <= '0; obit <= '0;   out_first <= 1'b0;
      so_oe_q <= 1'b0;
      for (int i = 0; i < MEM_BYTES; i++)  mem[i]  <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'h00;
    end else begin
      if (cyc_end) wel <= 1'b0;
      if (cs_start) begin
        state <= ST_CMD;
        so_oe_q <= 1'b0;
      end else if (cs_end) begin
        state <= ST_CMD;
        so_oe_q <= 1'b0;
        if (commit_wr)
          for (int i = 0; i < PAGE_BYTES; i++)
            if (pval[i]) mem[{addr[AW-1:PW], PW'(i)}] <= pbuf[i];
        if (commit_sr) sr_nv <= sr_new;
        pval   <= '0;
        got_sr <= 1'b0;
      end else if (byte_done) begin
        unique case (state)
          ST_CMD: begin
            state <= ST_SKIP;
            if (rx_byte == CMD_STAT_RD) begin
              state <= ST_SRDATA;  out_byte <= status_word;
              obit <= '0;          out_first <= 1'b1;
            end else if (!busy) begin
              if (rx_byte == CMD_LATCH_ON)       wel <= 1'b1;
              else if (rx_byte == CMD_LATCH_OFF) wel <= 1'b0;
              else if (rx_byte == CMD_STAT_WR && wel) state <= ST_SRIN;
              else if (rx_byte[7:4] == 4'd0 && rx_byte[2:0] == CMD_LOW_RD) begin
                state <= ST_ADDR;  is_read <= 1'b1;
                op_hi <= (AW > 8) ? rx_byte[3] : 1'b0;
              end else if (rx_byte[7:4] == 4'd0 && rx_byte[2:0] == CMD_LOW_WR && wel) begin
                state <= ST_ADDR;  is_read <= 1'b0;
                op_hi <= (AW > 8) ? rx_byte[3] : 1'b0;
              end
            end
          end
          ST_ADDR: begin
            if (is_read) begin
              state <= ST_RDATA;
              out_byte  <= mem[full_addr(op_hi, rx_byte)];
              addr      <= full_addr(op_hi, rx_byte) + 1'b1;
              obit      <= '0;
              out_first <= 1'b1;
            end else begin
              state <= ST_WDATA;
              addr  <= full_addr(op_hi, rx_byte);
              pval  <= '0;
            end
          end
          ST_WDATA: begin
            pbuf[addr[PW-1:0]] <= rx_byte;
            pval[addr[PW-1:0]] <= 1'b1;
            addr <= page_step(addr);
          end
          ST_SRIN: begin
            sr_new <= sr_pick(rx_byte);
            got_sr <= 1'b1;
          end
          default: ;
        endcase
      end else if (sck_fall && out_state) begin
        if (out_first) begin
          out_first <= 1'b0;
          so_oe_q   <= 1'b1;
        end else if (obit == 3'd7) begin
          obit <= '0;
          if (state == ST_RDATA) begin
            out_byte <= mem[addr];
            addr     <= addr + 1'b1;
          end else begin
            out_byte <= status_word;
          end
        end else begin
          obit <= obit + 3'd1;
        end
      end
    end
  end

  assign spi_miso    = out_byte[3'd7 - obit];
  assign spi_miso_en = so_oe_q;

  assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_evt |=> addr[AW-1:PW] == $past(addr[AW-1:PW]));
  assert_write_needs_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_wr |-> wel);
  assert_status_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_sr |-> wel);
  assert_latch_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> !wel);
  assert_busy_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_end) |=> ($stable(wel) && $stable(sr_nv)));
  assert_oe_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_miso_en) |-> $past(sck_fall));
  assert_oe_needs_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_miso_en);
endmodule

// File: tb/test_spi_eeprom_slave.sv
module test_spi_eeprom_slave;
  localparam int WCLK = 1200;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csn = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_en;
  int   nrun = 0, nfail = 0;
  bit   mode3 = 1'b0, done = 1'b0, oe_seen;
  logic [7:0] exp_mem [512];
  logic [7:0] rbuf [80];

  always #4 clk = ~clk;

  spi_eeprom_slave #(.MEM_BYTES(512), .PAGE_BYTES(16), .WRITE_CLKS(WCLK), .SYNC_STAGES(2))
    i_spi_eeprom_slave (.clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck),
      .spi_mosi(mosi), .spi_miso(miso), .spi_miso_en(miso_en));

  task automatic chk(input string req, input int act, input int exp);
    nrun++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    oe_seen = 1'b0;
    wclk(HALF); csn = 1'b0; wclk(HALF);
  endtask

  task automatic desel();
    if (!mode3) sck = 1'b0;
    wclk(HALF); csn = 1'b1; wclk(2 * HALF);
  endtask

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - nb; b--) begin
      sck = 1'b0; mosi = tx[b];
      wclk(HALF);
      rx[b] = miso;
      if (miso_en) oe_seen = 1'b1;
      sck = 1'b1;
      wclk(HALF);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rdsr(s);
      if (!s[0]) return;
    end
  endtask

  // page write of n bytes, value = base + 7*i, model updated arithmetically
  task automatic page_write(input logic [8:0] a, input int n, input logic [7:0] base);
    logic [7:0] d, v;
    sel();
    xfer({4'b0, a[8], 3'b010}, d);
    xfer(a[7:0], d);
    for (int i = 0; i < n; i++) begin
      v = base + 8'(7 * i);
      xfer(v, d);
      exp_mem[{a[8:4], 4'((a[3:0] + i) % 16)}] = v;
    end
    desel();
  endtask

  task automatic stream_read(input logic [8:0] a, input int n);
    logic [7:0] d;
    sel();
    xfer({4'b0, a[8], 3'b011}, d);
    xfer(a[7:0], d);
    for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
    desel();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nrun++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'hFF;
    wclk(5); rst_n = 1'b1; wclk(5);

    // R11 reset state
    chk("R11 oe after reset", miso_en, 0);
    rdsr(s); chk("R11 status after reset", s, 8'h00);
    stream_read(9'h000, 4);
    for (int i = 0; i < 4; i++) chk("R11 array erased", rbuf[i], 8'hFF);

    // R4 write without latch ignored
    page_write(9'h010, 2, 8'h11);
    exp_mem[9'h010] = 8'hFF; exp_mem[9'h011] = 8'hFF;
    rdsr(s); chk("R4 no cycle without latch", s, 8'h00);
    stream_read(9'h010, 2);
    chk("R4 no write without latch", rbuf[0], 8'hFF);

    // R1 latch set / clear
    cmd1(8'h06); rdsr(s); chk("R1 latch on", s, 8'h02);
    cmd1(8'h04); rdsr(s); chk("R1 latch off", s, 8'h00);

    // R5 page wrap at top page, opcode carries A8; R10 oe low in inputs
    cmd1(8'h06);
    page_write(9'h1F3, 20, 8'h03);
    chk("R10 oe low while writing", oe_seen, 0);
    // R8 during busy: latch-off ignored, read ignored
    cmd1(8'h04);
    rdsr(s); chk("R8 latch kept while busy", s, 8'h03);
    sel(); xfer(8'h0B, d); xfer(8'hF0, d); xfer(8'h00, d); desel();
    chk("R8 read ignored while busy", oe_seen, 0);
    wait_ready();
    rdsr(s); chk("R9 latch cleared after cycle", s, 8'h00);
    // R6 read across top of array wraps to 0
    stream_read(9'h1F0, 18);
    for (int i = 0; i < 18; i++)
      chk("R5 R6 page wrap and array wrap", rbuf[i], exp_mem[9'((9'h1F0 + i) % 512)]);

    // R7 / R2: long status stream right after a commit
    cmd1(8'h06);
    page_write(9'h080, 1, 8'h5A);
    sel(); xfer(8'h05, d);
    for (int i = 0; i < 11; i++) xfer(8'h00, rbuf[i]);
    desel();
    for (int i = 0; i < 8; i++) chk("R7 R2 busy repeated", rbuf[i], 8'h03);
    chk("R7 R9 ready after cycle", rbuf[9], 8'h00);
    chk("R7 R9 ready after cycle", rbuf[10], 8'h00);

    // R4 trailing partial byte aborts
    cmd1(8'h06);
    sel(); xfer(8'h02, d); xfer(8'h20, d); xfer(8'h77, d); xbits(8'hA0, 3, d); desel();
    rdsr(s); chk("R4 partial aborts, latch kept", s, 8'h02);
    stream_read(9'h020, 1); chk("R4 partial not stored", rbuf[0], 8'hFF);

    // R3 status writes
    sel(); xfer(8'h01, d); xfer(8'hFF, d); desel();
    wait_ready();
    rdsr(s); chk("R3 only bits 7 3 2 stored", s, 8'h8C);
    sel(); xfer(8'h01, d); xfer(8'h00, d); desel();
    rdsr(s); chk("R3 no update without latch", s, 8'h8C);
    cmd1(8'h06);
    sel(); xfer(8'h01, d); xfer(8'h73, d); desel();
    wait_ready();
    rdsr(s); chk("R3 partial mask", s, 8'h00);

    // Sweep four pages, both SPI modes (R10, R5, R6)
    for (int m = 0; m < 2; m++) begin
      mode3 = (m == 1);
      sck = mode3; wclk(4);
      for (int p = 0; p < 4; p++) begin
        cmd1(8'h06);
        page_write(9'(p * 16), 16, 8'(p * 40 + m * 9 + 1));
        wait_ready();
      end
      stream_read(9'h000, 64);
      for (int i = 0; i < 64; i++) chk("R10 R6 sweep readback", rbuf[i], exp_mem[i]);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule